// File: doc/BRIEF.md
# Receive FIFO Read Port with Non-Intrusive Debug Access

This block is the consumer side of one channel's receive buffer. A shifter-side write port loads received words. A bus read strobe takes them out, and a qualifier on the strobe marks each access as either an application access or an emulator access. An application read removes the head word, and it clears the channel's receive-full status flag and with it the interrupt request. An emulator read returns the same head word but changes nothing: the word stays unread, the read pointer stays where it is, and the status flag and interrupt request keep their values. Words that arrive during emulator accesses still update the status flag as usual.

A mode input selects between a DEPTH-entry first-in first-out buffer and a single-entry holding register. Read data is registered. It appears on the cycle after the read strobe and holds its value until the next read that finds data available. The interrupt request is the status flag gated by an enable input.

Top module: `rx_dbg_rdport`

## Requirements
- R1: While rst_ni is low and after its release, status_o, irq_o and rd_data_o are all 0.
- R2: An accepted write sets status_o at the following clock edge. A write is accepted in buffer mode (fifo_en_i=1) when fewer than DEPTH words are held, and it is always accepted in holding mode.
- R3: irq_o is high exactly when status_o is high and irq_en_i is high.
- R4: An application read (rd_en_i=1, dbg_i=0) clears status_o at the next edge unless an accepted write occurs in the same cycle, in which case status_o is 1.
- R5: An emulator read (rd_en_i=1, dbg_i=1) puts the head word on rd_data_o one cycle later, leaves status_o unchanged, and does not remove the word, so the next read returns it again.
- R6: In buffer mode, application reads return words in the order they were written.
- R7: A read that finds no data available leaves rd_data_o at its previous value and moves no pointer, so a later write and read return the new word.
- R8: In buffer mode, a write while DEPTH words are held is dropped, and the held words are unaffected.
- R9: In holding mode (fifo_en_i=0), a write overwrites the single entry, and an application read marks the entry empty.
- R10: An accepted write in the same cycle as an emulator read sets status_o and is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: buffer mode, 0: single holding register |
| wr_en_i | input | 1 | Write strobe from the shifter |
| wr_data_i | input | DATA_W | Received word |
| rd_en_i | input | 1 | Bus read strobe |
| dbg_i | input | 1 | 1 marks the read as an emulator access |
| irq_en_i | input | 1 | Receive-full interrupt enable |
| rd_data_o | output | DATA_W | Registered read data |
| status_o | output | 1 | Receive-full status flag |
| irq_o | output | 1 | Receive-full interrupt request |

## Verification
The read path is tried with several patterns. Repeated emulator reads of one word separate a non-destructive read from a popping read. Application reads issued past the last word check that an empty buffer returns the last data. A write that coincides with an application read, and another that coincides with an emulator read, show how a set and a clear of the status flag interact. Filling the buffer past DEPTH and then draining it shows that the extra write was dropped. In holding mode, two writes in a row followed by reads separate overwrite from queueing.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic {
    SRC_HOLD = 1'b0,
    SRC_FIFO = 1'b1
  } rx_src_e;
endpackage

// File: rtl/rxr_fifo_store.sv
module rxr_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW:0]       wptr_q, rptr_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              do_push, do_pop;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rptr_q[AW-1:0]];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mem_q[e] <= '0;
      else if (do_push && wptr_q[AW-1:0] == AW'(e))      mem_q[e] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxr_hold_reg.sv
module rxr_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clear_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      data_o  <= data_i;
      valid_o <= 1'b1;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rxr_status.sv
module rxr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clear_i,
  input  logic irq_en_i,
  output logic status_o,
  output logic irq_o
);
  // set wins over clear: a new word is always unread
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_o <= 1'b0;
    else if (set_i)   status_o <= 1'b1;
    else if (clear_i) status_o <= 1'b0;
  end

  assign irq_o = status_o & irq_en_i;
endmodule

// File: rtl/rx_dbg_rdport.sv
module rx_dbg_rdport
  import rxr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              dbg_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              status_o,
  output logic              irq_o
);
  rx_src_e           src;
  logic              app_rd;
  logic              fifo_full, fifo_empty;
  logic [DATA_W-1:0] fifo_head, hold_data;
  logic              hold_valid;
  logic              wr_accept;
  logic              head_avail;
  logic [DATA_W-1:0] head_word;
  logic [DATA_W-1:0] rd_data_q;

  assign src    = fifo_en_i ? SRC_FIFO : SRC_HOLD;
  assign app_rd = rd_en_i && !dbg_i;

  rxr_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i && src == SRC_FIFO),
    .data_i  (wr_data_i),
    .pop_i   (app_rd && src == SRC_FIFO),
    .head_o  (fifo_head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  rxr_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr_en_i && src == SRC_HOLD),
    .data_i  (wr_data_i),
    .clear_i (app_rd && src == SRC_HOLD),
    .data_o  (hold_data),
    .valid_o (hold_valid)
  );

  always_comb begin
    if (src == SRC_FIFO) begin
      wr_accept  = wr_en_i && !fifo_full;
      head_avail = !fifo_empty;
      head_word  = fifo_head;
    end else begin
      wr_accept  = wr_en_i;
      head_avail = hold_valid;
      head_word  = hold_data;
    end
  end

  rxr_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (wr_accept),
    .clear_i  (app_rd),
    .irq_en_i (irq_en_i),
    .status_o (status_o),
    .irq_o    (irq_o)
  );

  // debug and application reads share the data path; only app_rd touches state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rd_data_q <= '0;
    else if (rd_en_i && head_avail)  rd_data_q <= head_word;
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/rx_dbg_rdport_chk.sv
module rx_dbg_rdport_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              dbg_i,
  input logic              irq_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              status_o,
  input logic              irq_o,
  input logic              wr_accept,
  input logic              head_avail
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!status_o && !irq_o && rd_data_o == '0));

  assert_write_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_accept |=> status_o);

  assert_irq_needs_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o && irq_en_i));

  assert_irq_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && irq_en_i) |-> irq_o);

  assert_app_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !dbg_i && !wr_accept) |=> !status_o);

  assert_dbg_keeps_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && dbg_i && !wr_accept) |=> $stable(status_o));

  assert_empty_read_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !head_avail) |=> $stable(rd_data_o));

  assert_no_read_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  assert_dbg_write_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && dbg_i && wr_accept) |=> status_o);
endmodule

bind rx_dbg_rdport rx_dbg_rdport_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .dbg_i      (dbg_i),
  .irq_en_i   (irq_en_i),
  .rd_data_o  (rd_data_o),
  .status_o   (status_o),
  .irq_o      (irq_o),
  .wr_accept  (wr_accept),
  .head_avail (head_avail)
);

// File: tb/rx_dbg_rdport_bench.sv
module rx_dbg_rdport_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int NVEC   = 12;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fifo_en_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0, dbg_i = 1'b0, irq_en_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              status_o, irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  rx_dbg_rdport #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_dbg_rdport (
    .clk_i, .rst_ni, .fifo_en_i, .wr_en_i, .wr_data_i, .rd_en_i, .dbg_i, .irq_en_i,
    .rd_data_o, .status_o, .irq_o
  );

  // {fifo_en, wr, wdata[8], rd, dbg, irq_en} -> {status, irq, rdata[8]}
  localparam logic [22:0] VECS [NVEC] = '{
    {1'b1, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00},  // R2 R3
    {1'b1, 1'b1, 8'hA2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00},  // R2
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA1},  // R5
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA1},  // R5 no pop
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1},  // R4
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA2},  // R6
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA2},  // R7
    {1'b1, 1'b1, 8'hB1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA2},  // R3 masked
    {1'b1, 1'b1, 8'hB2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hB1},  // R10
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hB1},  // R4
    {1'b1, 1'b1, 8'hB3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hB2},  // R4 set wins, R10 stored
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hB3}   // R6
  };

  string tags [NVEC] = '{"R2", "R2", "R5", "R5", "R4", "R6", "R7", "R3", "R10", "R4", "R4", "R6"};

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic fen, input logic wr, input logic [DATA_W-1:0] wd,
                      input logic rd, input logic dbg, input logic ien);
    fifo_en_i = fen; wr_en_i = wr; wr_data_i = wd; rd_en_i = rd; dbg_i = dbg; irq_en_i = ien;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk_i);
    check("R1 status", {7'b0, status_o}, 8'h00);
    check("R1 data", rd_data_o, 8'h00);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R1 irq", {7'b0, irq_o}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i][22], VECS[i][21], VECS[i][20:13], VECS[i][12], VECS[i][11], VECS[i][10]);
      check({tags[i], " status"}, {7'b0, status_o}, {7'b0, VECS[i][9]});
      check({tags[i], " irq"},    {7'b0, irq_o},    {7'b0, VECS[i][8]});
      check({tags[i], " data"},   rd_data_o,        VECS[i][7:0]);
    end

    // R8: fill past DEPTH, the fifth word is dropped
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 1'b1, 8'hC1 + 8'(i), 1'b0, 1'b0, 1'b0);
    check("R2 status after fill", {7'b0, status_o}, 8'h01);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      check("R8 R6 drain order", rd_data_o, 8'hC1 + 8'(i));
    end
    check("R4 status drained", {7'b0, status_o}, 8'h00);
    step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R8 dropped word absent", rd_data_o, 8'hC4);

    // R9 holding mode
    step(1'b0, 1'b1, 8'hD1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 8'hD2, 1'b0, 1'b0, 1'b1);
    check("R9 status", {7'b0, status_o}, 8'h01);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    check("R9 R5 dbg read", rd_data_o, 8'hD2);
    check("R5 hold status kept", {7'b0, irq_o}, 8'h01);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    check("R9 overwrite", rd_data_o, 8'hD2);
    check("R9 R4 cleared", {7'b0, status_o}, 8'h00);
    step(1'b0, 1'b1, 8'hD3, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R9 new word", rd_data_o, 8'hD3);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R7 hold empty read", rd_data_o, 8'hD3);

    // R1 reset mid-run
    step(1'b1, 1'b1, 8'hE1, 1'b0, 1'b0, 1'b1);
    rst_ni = 1'b0;
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R1 rerst status", {7'b0, status_o}, 8'h00);
    check("R1 rerst irq", {7'b0, irq_o}, 8'h00);
    check("R1 rerst data", rd_data_o, 8'h00);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    check("R1 R7 empty after reset", rd_data_o, 8'h00);

    finish_run();
  end
endmodule